// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Protection with Error Log

This block sits between a memory read/write datapath and a memory that stores an 8-bit check code next to each data word. On the write side it computes the check code for a data word and presents data and code together in the same cycle. On the read side it recomputes the code and compares it with the stored one. It repairs any single flipped bit before the data leaves, and it marks any two-bit upset as uncorrectable. The block never writes repaired data back into memory. Rewriting a repaired location is left to software.

A mode input picks between a 64-bit data path and a 32-bit data path. In the narrow mode the 32-bit datum is padded with zeros to 64 bits, so the same 8-bit code is generated, checked and used for repair. The stored word then takes 40 bits. When reporting is enabled, each detected error is logged with its kind and its address into the first free of two log slots. Once both slots hold entries, further errors only raise a sticky overflow flag.

Top module: `secded_ecc_log`

## Requirements
- R1: `wr_word_o` is combinational. Bits [63:0] carry the data and bits [71:64] carry the code. Code bit j is the XOR of every data bit i whose column has bit j set. The column of data bit i is the i-th 8-bit value of odd weight of at least 3, with values ordered first by weight and then by numeric value. Check bit j has a column with only bit j set.
- R2: A read whose stored code matches its data returns the data unchanged. Neither error flag is set, and the result appears one clock after the read is presented.
- R3: If exactly one data bit of a read word is flipped, the repaired data is delivered and `rd_sbe_o` is set.
- R4: If the only flipped bit is a check bit, the data is returned unchanged and `rd_sbe_o` is still set.
- R5: If any two bits of the 72-bit word are flipped, `rd_mbe_o` is set, `rd_sbe_o` stays low, and the data is passed on without modification.
- R6: With `narrow_i` high, data bits [63:32] of both the write input and the read word are ignored and treated as zero. `wr_word_o` and `rd_data_o` carry zeros there, and the code covers the zero-extended word.
- R7: With `narrow_i` high, a syndrome equal to the column of a data bit in [63:32] is reported as uncorrectable (`rd_mbe_o`).
- R8: `rd_valid_o` equals `rd_valid_i` delayed by one clock. Both error flags are low whenever `rd_valid_o` is low.
- R9: With `report_en_i` high, a detected error fills the lowest-numbered slot that is not valid. The slot records the kind (`log_multi_o` = 1 for uncorrectable) and the read address, visible one clock after the read.
- R10: An error that finds every slot valid sets `log_ovf_o` and leaves every slot unchanged. `log_ovf_o` stays set until it is cleared.
- R11: A one-cycle pulse on `log_clr_i[s]` clears slot s, and a pulse on `ovf_clr_i` clears the overflow flag. An error in the same cycle as a slot clear sees that slot as free. An error that overflows in the same cycle as `ovf_clr_i` leaves the flag set.
- R12: With `report_en_i` low, errors are still corrected and flagged, but no slot and no overflow flag changes.
- R13: After reset, `rd_valid_o`, both error flags, every slot and the overflow flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_i | input | 1 | 1 selects the 32-bit data path |
| report_en_i | input | 1 | Enables error logging |
| wr_data_i | input | 64 | Write data |
| wr_word_o | output | 72 | Code and data for storage |
| rd_valid_i | input | 1 | Read word present |
| rd_word_i | input | 72 | Stored word read back |
| rd_addr_i | input | 32 | Address of the read word |
| rd_valid_o | output | 1 | Read result present |
| rd_data_o | output | 64 | Repaired read data |
| rd_sbe_o | output | 1 | Single error repaired |
| rd_mbe_o | output | 1 | Uncorrectable error |
| log_clr_i | input | 2 | Per-slot clear pulse |
| ovf_clr_i | input | 1 | Overflow clear pulse |
| log_valid_o | output | 2 | Slot holds an entry |
| log_multi_o | output | 2 | Slot entry is uncorrectable |
| log_addr_o | output | 2x32 | Slot addresses, slot s in bits [32s+31:32s] |
| log_ovf_o | output | 1 | Sticky overflow |

## Verification
The write path is driven with all-zero, all-one, alternating and random data in both widths. This confirms the code matrix column by column and shows that the upper half is masked in narrow mode. Reads are tried with four kinds of damage:
- a flip in every one of the 64 data positions, which separates each column match from its neighbours;
- a flip in each of the 8 check positions, which separates check-only repair from data repair;
- random two-bit flips, which must never be repaired;
- in narrow mode, a check-field damage equal to an upper-half column, which must be reported as uncorrectable rather than applied.

The logging sequences fill both slots with mixed kinds, overflow them, and clear in the same cycle as a new error. They also run with reporting off, which tells the slot selection order apart from the overflow and clear priorities.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'd0,
      ERR_SINGLE = 2'd1,
      ERR_MULTI  = 2'd2
   } err_kind_e;

   // Column of data bit idx: idx-th odd-weight (>=3) value of cw bits,
   // ordered by weight then by value.
   function automatic logic [15:0] data_column(int idx, int cw);
      logic [15:0] res = '0;
      int n = 0;
      for (int w = 3; w <= cw; w += 2) begin
         for (int v = 0; v < (1 << cw); v++) begin
            if ($countones(v) == w) begin
               if (n == idx) res = 16'(v);
               n++;
            end
         end
      end
      return res;
   endfunction

   // Number of distinct data columns available for a cw-bit code.
   function automatic int column_capacity(int cw);
      int n = 0;
      for (int w = 3; w <= cw; w += 2) begin
         for (int v = 0; v < (1 << cw); v++) begin
            if ($countones(v) == w) n++;
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/secded_encode.sv
module secded_encode #(
   parameter int DATA_W = 64,
   parameter int CODE_W = 8
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o
);

   logic [DATA_W-1:0][CODE_W-1:0] term;

   for (genvar i = 0; i < DATA_W; i++) begin : g_term
      localparam logic [CODE_W-1:0] COL = CODE_W'(secded_pkg::data_column(i, CODE_W));
      assign term[i] = data_i[i] ? COL : '0;
   end

   always_comb begin
      code_o = '0;
      for (int i = 0; i < DATA_W; i++) begin
         code_o = code_o ^ term[i];
      end
   end

endmodule

// File: rtl/secded_decode.sv
module secded_decode
   import secded_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int CODE_W   = 8,
   parameter int NARROW_W = 32
) (
   input  logic              narrow_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] data_o,
   output err_kind_e         kind_o
);

   logic [DATA_W-1:0] data_ext;
   logic [CODE_W-1:0] recalc;
   logic [CODE_W-1:0] syn;
   logic [DATA_W-1:0] flip;
   logic              chk_hit;

   assign data_ext = narrow_i
                   ? {{(DATA_W-NARROW_W){1'b0}}, data_i[NARROW_W-1:0]}
                   : data_i;

   secded_encode #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_recalc (
      .data_i (data_ext),
      .code_o (recalc)
   );

   assign syn = recalc ^ code_i;

   for (genvar i = 0; i < DATA_W; i++) begin : g_flip
      localparam logic [CODE_W-1:0] COL = CODE_W'(secded_pkg::data_column(i, CODE_W));
      if (i < NARROW_W) begin : g_low
         assign flip[i] = (syn == COL);
      end else begin : g_high
         assign flip[i] = !narrow_i && (syn == COL);
      end
   end

   assign chk_hit = $onehot(syn);

   always_comb begin
      if (syn == '0)              kind_o = ERR_NONE;
      else if (|flip || chk_hit)  kind_o = ERR_SINGLE;
      else                        kind_o = ERR_MULTI;
   end

   assign data_o = data_ext ^ flip;

endmodule

// File: rtl/secded_err_log.sv
module secded_err_log #(
   parameter int ADDR_W = 32,
   parameter int SLOTS  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rec_i,
   input  logic                         multi_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [SLOTS-1:0]             clr_i,
   input  logic                         ovf_clr_i,
   output logic [SLOTS-1:0]             valid_o,
   output logic [SLOTS-1:0]             multi_o,
   output logic [SLOTS-1:0][ADDR_W-1:0] addr_o,
   output logic                         ovf_o
);

   logic [SLOTS-1:0] free;
   logic [SLOTS-1:0] pick;
   logic             found;

   assign free = ~valid_o | clr_i;

   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
         if (free[s] && !found) begin
            pick[s] = 1'b1;
            found   = 1'b1;
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o[s] <= 1'b0;
            multi_o[s] <= 1'b0;
            addr_o[s]  <= '0;
         end else if (rec_i && pick[s]) begin
            valid_o[s] <= 1'b1;
            multi_o[s] <= multi_i;
            addr_o[s]  <= addr_i;
         end else if (clr_i[s]) begin
            valid_o[s] <= 1'b0;
            multi_o[s] <= 1'b0;
            addr_o[s]  <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ovf_o <= 1'b0;
      else if (rec_i && !found) ovf_o <= 1'b1;
      else if (ovf_clr_i)       ovf_o <= 1'b0;
   end

endmodule

// File: rtl/secded_ecc_log.sv
module secded_ecc_log
   import secded_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int CODE_W   = 8,
   parameter int NARROW_W = 32,
   parameter int ADDR_W   = 32,
   parameter int SLOTS    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         narrow_i,
   input  logic                         report_en_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   output logic [DATA_W+CODE_W-1:0]     wr_word_o,
   input  logic                         rd_valid_i,
   input  logic [DATA_W+CODE_W-1:0]     rd_word_i,
   input  logic [ADDR_W-1:0]            rd_addr_i,
   output logic                         rd_valid_o,
   output logic [DATA_W-1:0]            rd_data_o,
   output logic                         rd_sbe_o,
   output logic                         rd_mbe_o,
   input  logic [SLOTS-1:0]             log_clr_i,
   input  logic                         ovf_clr_i,
   output logic [SLOTS-1:0]             log_valid_o,
   output logic [SLOTS-1:0]             log_multi_o,
   output logic [SLOTS-1:0][ADDR_W-1:0] log_addr_o,
   output logic                         log_ovf_o
);

   localparam int WORD_W = DATA_W + CODE_W;
   localparam int PAD_W  = DATA_W - NARROW_W;

   // elaboration-time parameter checks
   if (NARROW_W < 1 || NARROW_W >= DATA_W) begin : g_bad_narrow
      $error("narrow width must be between 1 and DATA_W-1");
   end
   if (CODE_W < 4 || CODE_W > 16) begin : g_bad_code
      $error("code width must be between 4 and 16");
   end
   if (secded_pkg::column_capacity(CODE_W) < DATA_W) begin : g_bad_cap
      $error("code width too small for the data width");
   end
   if (SLOTS < 1) begin : g_bad_slots
      $error("at least one log slot is required");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("address width must be positive");
   end

   // ---------------- write path ----------------
   logic [DATA_W-1:0] wr_ext;
   logic [CODE_W-1:0] wr_code;

   assign wr_ext = narrow_i ? {{PAD_W{1'b0}}, wr_data_i[NARROW_W-1:0]} : wr_data_i;

   secded_encode #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_wr_enc (
      .data_i (wr_ext),
      .code_o (wr_code)
   );

   assign wr_word_o = {wr_code, wr_ext};

   // ---------------- read path ----------------
   logic [DATA_W-1:0] fix_data;
   err_kind_e         fix_kind;

   secded_decode #(.DATA_W(DATA_W), .CODE_W(CODE_W), .NARROW_W(NARROW_W)) u_dec (
      .narrow_i (narrow_i),
      .data_i   (rd_word_i[DATA_W-1:0]),
      .code_i   (rd_word_i[WORD_W-1:DATA_W]),
      .data_o   (fix_data),
      .kind_o   (fix_kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_sbe_o   <= 1'b0;
         rd_mbe_o   <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= rd_valid_i;
         rd_sbe_o   <= rd_valid_i && (fix_kind == ERR_SINGLE);
         rd_mbe_o   <= rd_valid_i && (fix_kind == ERR_MULTI);
         if (rd_valid_i) rd_data_o <= fix_data;
      end
   end

   // ---------------- error log ----------------
   logic rec;
   assign rec = rd_valid_i && report_en_i && (fix_kind != ERR_NONE);

   secded_err_log #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .rec_i     (rec),
      .multi_i   (fix_kind == ERR_MULTI),
      .addr_i    (rd_addr_i),
      .clr_i     (log_clr_i),
      .ovf_clr_i (ovf_clr_i),
      .valid_o   (log_valid_o),
      .multi_o   (log_multi_o),
      .addr_o    (log_addr_o),
      .ovf_o     (log_ovf_o)
   );

endmodule

// File: rtl/secded_ecc_log_chk.sv
module secded_ecc_log_chk #(
   parameter int DATA_W   = 64,
   parameter int CODE_W   = 8,
   parameter int NARROW_W = 32,
   parameter int ADDR_W   = 32,
   parameter int SLOTS    = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         narrow_i,
   input logic                         report_en_i,
   input logic [DATA_W+CODE_W-1:0]     wr_word_o,
   input logic                         rd_valid_i,
   input logic                         rd_valid_o,
   input logic [DATA_W-1:0]            rd_data_o,
   input logic                         rd_sbe_o,
   input logic                         rd_mbe_o,
   input logic [SLOTS-1:0]             log_clr_i,
   input logic                         ovf_clr_i,
   input logic [SLOTS-1:0]             log_valid_o,
   input logic [SLOTS-1:0][ADDR_W-1:0] log_addr_o,
   input logic                         log_ovf_o
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R5
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_sbe_o && rd_mbe_o));

   // R8
   flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sbe_o || rd_mbe_o) |-> rd_valid_o);

   // R8
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (rd_valid_o == $past(rd_valid_i)));

   // R6
   narrow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      narrow_i |-> (wr_word_o[DATA_W-1:NARROW_W] == '0));

   // R6
   narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rd_valid_o && $past(narrow_i)) |-> (rd_data_o[DATA_W-1:NARROW_W] == '0));

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (log_ovf_o && !ovf_clr_i) |=> log_ovf_o);

   // R12
   quiet_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!report_en_i && log_valid_o == '0) |=> (log_valid_o == '0));

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
      // R10
      slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (log_valid_o[s] && !log_clr_i[s]) |=> (log_valid_o[s] && $stable(log_addr_o[s])));
   end

endmodule

bind secded_ecc_log secded_ecc_log_chk #(
   .DATA_W(DATA_W), .CODE_W(CODE_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .narrow_i    (narrow_i),
   .report_en_i (report_en_i),
   .wr_word_o   (wr_word_o),
   .rd_valid_i  (rd_valid_i),
   .rd_valid_o  (rd_valid_o),
   .rd_data_o   (rd_data_o),
   .rd_sbe_o    (rd_sbe_o),
   .rd_mbe_o    (rd_mbe_o),
   .log_clr_i   (log_clr_i),
   .ovf_clr_i   (ovf_clr_i),
   .log_valid_o (log_valid_o),
   .log_addr_o  (log_addr_o),
   .log_ovf_o   (log_ovf_o)
);

// File: tb/secded_ecc_log_test.sv
`timescale 1ns/1ps
module secded_ecc_log_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        narrow = 1'b0;
   logic        report_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [71:0] wr_word;
   logic        rd_valid = 1'b0;
   logic [71:0] rd_word = '0;
   logic [31:0] rd_addr = '0;
   logic        q_valid, q_sbe, q_mbe;
   logic [63:0] q_data;
   logic [1:0]  log_clr = '0;
   logic        ovf_clr = 1'b0;
   logic [1:0]  lv, lm;
   logic [1:0][31:0] la;
   logic        lovf;

   always #2.5 clk = ~clk;

   secded_ecc_log uut (
      .clk(clk), .rst_n(rst_n), .narrow_i(narrow), .report_en_i(report_en),
      .wr_data_i(wr_data), .wr_word_o(wr_word),
      .rd_valid_i(rd_valid), .rd_word_i(rd_word), .rd_addr_i(rd_addr),
      .rd_valid_o(q_valid), .rd_data_o(q_data), .rd_sbe_o(q_sbe), .rd_mbe_o(q_mbe),
      .log_clr_i(log_clr), .ovf_clr_i(ovf_clr),
      .log_valid_o(lv), .log_multi_o(lm), .log_addr_o(la), .log_ovf_o(lovf)
   );

   int total = 0;
   int bad = 0;
   string tag = "R13";

   // ---------------- reference model ----------------
   logic [7:0] colv [64];
   initial begin
      int n;
      n = 0;
      for (int w = 3; w <= 8; w += 2)
         for (int v = 0; v < 256; v++)
            if ($countones(v) == w && n < 64) begin
               colv[n] = 8'(v);
               n++;
            end
   end

   function automatic logic [7:0] ref_code(logic [63:0] d);
      logic [7:0] c = '0;
      for (int i = 0; i < 64; i++) if (d[i]) c = c ^ colv[i];
      return c;
   endfunction

   function automatic logic [63:0] ext_of(logic nar, logic [63:0] d);
      return nar ? {32'h0, d[31:0]} : d;
   endfunction

   logic        e_valid, e_sbe, e_mbe, e_ovf;
   logic [63:0] e_data;
   logic [1:0]  e_lv, e_lm;
   logic [31:0] e_la [2];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid = 0; e_sbe = 0; e_mbe = 0; e_ovf = 0; e_data = '0;
         e_lv = '0; e_lm = '0; e_la[0] = '0; e_la[1] = '0;
      end else begin
         logic [63:0] d;
         logic [7:0]  s;
         int          kind;
         int          lim;
         d = ext_of(narrow, rd_word[63:0]);
         s = ref_code(d) ^ rd_word[71:64];
         kind = 0;
         if (s != 0) begin
            kind = 2;
            lim = narrow ? 32 : 64;
            for (int i = 0; i < lim; i++)
               if (colv[i] == s) begin kind = 1; d[i] = ~d[i]; end
            for (int j = 0; j < 8; j++) if (s == 8'(1 << j)) kind = 1;
         end
         e_valid = rd_valid;
         e_sbe = rd_valid && kind == 1;
         e_mbe = rd_valid && kind == 2;
         if (rd_valid) e_data = d;
         for (int k = 0; k < 2; k++)
            if (log_clr[k]) begin e_lv[k] = 0; e_lm[k] = 0; e_la[k] = '0; end
         if (rd_valid && report_en && kind != 0) begin
            if (!e_lv[0]) begin e_lv[0] = 1; e_lm[0] = (kind == 2); e_la[0] = rd_addr; end
            else if (!e_lv[1]) begin e_lv[1] = 1; e_lm[1] = (kind == 2); e_la[1] = rd_addr; end
            else e_ovf = 1;
         end else if (ovf_clr) e_ovf = 0;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_now();
      chk("R8", "rd_valid_o", 128'(q_valid), 128'(e_valid));
      if (e_valid) begin
         chk(tag, "rd_data_o", 128'(q_data), 128'(e_data));
         chk(tag, "rd_sbe_o", 128'(q_sbe), 128'(e_sbe));
         chk(tag, "rd_mbe_o", 128'(q_mbe), 128'(e_mbe));
      end else begin
         chk("R8", "idle flags", 128'({q_sbe, q_mbe}), 128'(0));
      end
      chk(tag, "log_valid_o", 128'(lv), 128'(e_lv));
      chk(tag, "log_multi_o", 128'(lm), 128'(e_lm));
      chk(tag, "log_addr_o0", 128'(la[0]), 128'(e_la[0]));
      chk(tag, "log_addr_o1", 128'(la[1]), 128'(e_la[1]));
      chk(tag, "log_ovf_o", 128'(lovf), 128'(e_ovf));
      chk(narrow ? "R6" : "R1", "wr_word_o", 128'(wr_word),
          128'({ref_code(ext_of(narrow, wr_data)), ext_of(narrow, wr_data)}));
   endtask

   task automatic cycle();
      @(posedge clk);
      #1;
      check_now();
      log_clr = '0;
      ovf_clr = 1'b0;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   task automatic rd(logic [63:0] d, logic [71:0] dmg, logic [31:0] a);
      logic [63:0] x;
      x = ext_of(narrow, d);
      rd_word  = {ref_code(x), x} ^ dmg;
      if (narrow) rd_word[63:32] = rnd64()[31:0];
      rd_addr  = a;
      rd_valid = 1'b1;
      wr_data  = rnd64();
      cycle();
   endtask

   task automatic idle();
      rd_valid = 1'b0;
      cycle();
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tag = "R13";
      cycle();

      // write path, wide
      tag = "R1";
      foreach (wr_data[i]) ;
      wr_data = '0;                     cycle();
      wr_data = '1;                     cycle();
      wr_data = 64'haaaa_aaaa_aaaa_aaaa; cycle();
      for (int k = 0; k < 64; k++) begin wr_data = 64'(1) << k; cycle(); end
      repeat (4) begin wr_data = rnd64(); cycle(); end

      tag = "R2";
      rd('0, '0, 32'h10);
      rd('1, '0, 32'h11);
      repeat (4) rd(rnd64(), '0, 32'h12);
      idle();

      tag = "R3";
      for (int b = 0; b < 64; b++) rd(rnd64(), 72'(1) << b, 32'(b));
      idle();

      tag = "R4";
      for (int j = 0; j < 8; j++) rd(rnd64(), 72'(1) << (64 + j), 32'(j));
      idle();

      tag = "R5";
      for (int k = 0; k < 16; k++) begin
         int a, b;
         a = $urandom_range(71, 0);
         b = (a + 1 + $urandom_range(70, 0)) % 72;
         rd(rnd64(), (72'(1) << a) | (72'(1) << b), 32'(k));
      end
      idle();

      tag = "R6";
      narrow = 1'b1;
      wr_data = '1; cycle();
      repeat (3) begin wr_data = rnd64(); cycle(); end
      repeat (3) rd(rnd64(), '0, 32'h20);
      for (int b = 0; b < 32; b++) rd(rnd64(), 72'(1) << b, 32'(b));
      rd(rnd64(), 72'(1) << 66, 32'h21);
      idle();

      tag = "R7";
      for (int b = 32; b < 64; b += 5) rd(rnd64(), {colv[b], 64'h0}, 32'(b));
      idle();
      narrow = 1'b0;

      tag = "R12";
      report_en = 1'b0;
      rd(rnd64(), 72'(1) << 7, 32'h30);
      rd(rnd64(), 72'h3, 32'h31);
      idle();

      tag = "R9";
      report_en = 1'b1;
      rd(rnd64(), 72'(1) << 12, 32'h0000_0100);
      rd(rnd64(), '0, 32'h0000_0150);
      rd(rnd64(), (72'(1) << 3) | (72'(1) << 70), 32'h0000_0200);
      idle();

      tag = "R10";
      rd(rnd64(), 72'(1) << 40, 32'h0000_0300);
      idle();
      rd(rnd64(), 72'h5, 32'h0000_0310);
      idle();

      tag = "R11";
      log_clr = 2'b01; idle();
      rd(rnd64(), 72'(1) << 68, 32'h0000_0400);
      ovf_clr = 1'b1; idle();
      idle();
      log_clr = 2'b10;
      rd(rnd64(), 72'(1) << 1, 32'h0000_0500);
      log_clr = 2'b01;
      rd(rnd64(), 72'h30, 32'h0000_0600);
      rd(rnd64(), 72'(1) << 9, 32'h0000_0700);
      ovf_clr = 1'b1;
      rd(rnd64(), 72'(1) << 9, 32'h0000_0800);
      ovf_clr = 1'b1; idle();
      log_clr = 2'b11; idle();
      idle();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule